// File: doc/BRIEF.md
# Masked scalar single-precision subtract unit

The unit subtracts one IEEE-754 binary32 value from another on the lowest 32-bit lane of 128-bit vector operands. It returns a full-width destination vector of MAXVL bits together with five exception flags. There are two forms. The legacy two-operand form takes the old destination as the minuend. The three-operand form takes the minuend from a separate source vector and rebuilds the upper lanes from that source.

The three-operand form can also gate the result lane with a one-bit write mask. When the mask bit is clear, the lane either keeps its old contents (merge mode) or is cleared (zero mode). The rounding mode normally comes from a global 2-bit control field. A per-operation mode replaces it when the override is enabled and the second source comes from a register. Subnormal operands and results keep full precision and are never flushed.

A result is captured one cycle after the `valid_i` strobe and is marked by a one-cycle `valid_o` pulse. The registered outputs hold between operations.

Top module: `masked_fsub_unit`

## Requirements
- R1: `dest_o[31:0]` is the correctly rounded binary32 value of the minuend's low lane minus `src2_i[31:0]`. An exact result sets no flag.
- R2: Rounding mode codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. The mode is `rc_ovr_mode_i` when both `rc_ovr_i` and `src2_is_reg_i` are 1; otherwise it is `rc_global_i`. A rounded result sets inexact (flags bit 0).
- R3: On overflow, nearest-even returns infinity. Toward zero returns the largest finite value of the same sign. Toward plus infinity returns +infinity or -max, and toward minus infinity returns +max or -infinity. Overflow (bit 2) and inexact (bit 0) are set.
- R4: A signaling NaN input, or infinity minus an infinity of the same sign, returns 0xFFC00000 and sets invalid (bit 4).
- R5: With no signaling NaN present, a quiet NaN input is returned unchanged, and the minuend wins when both are NaN. An infinite operand with a finite or opposite-signed infinite partner gives an infinity with no flag set.
- R6: An exact zero difference of operands with opposite effective signs is +0, except toward minus infinity, where it is -0. Two zeros of equal effective sign keep that sign.
- R7: A subnormal input sets denormal (bit 3). A non-zero subnormal result is returned exactly and sets underflow (bit 1).
- R8: In the three-operand form with `mask_en_i`=1 and `mask_bit_i`=0, the low lane keeps `dest_i[31:0]` when `zero_mask_i`=0 and becomes zero when `zero_mask_i`=1. In both cases all five flags are 0.
- R9: In the three-operand form (`three_op_i`=1), bits 127:32 come from `src1_i` and bits MAXVL-1:128 are zero.
- R10: In the legacy form (`three_op_i`=0), the minuend is `dest_i[31:0]`, bits MAXVL-1:32 equal `dest_i`, and the mask inputs are ignored. The unmasked three-operand form also always writes the difference.
- R11: `valid_o` pulses one cycle after `valid_i`. `dest_o` and `flags_o` change only on an accepted operation. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| three_op_i | input | 1 | 1: three-operand form, 0: legacy form |
| mask_en_i | input | 1 | Write mask in use (three-operand form only) |
| mask_bit_i | input | 1 | Write mask bit for the low lane |
| zero_mask_i | input | 1 | 1: zero masking, 0: merge masking |
| rc_ovr_i | input | 1 | Per-operation rounding override enable |
| rc_ovr_mode_i | input | 2 | Per-operation rounding mode |
| rc_global_i | input | 2 | Global rounding mode |
| src2_is_reg_i | input | 1 | Second source is a register |
| src1_i | input | 128 | First source vector |
| src2_i | input | 128 | Second source vector (low lane used) |
| dest_i | input | MAXVL | Old destination value |
| valid_o | output | 1 | Result strobe |
| dest_o | output | MAXVL | New destination value |
| flags_o | output | 5 | {invalid, denormal, overflow, underflow, inexact} |

## Verification
An exhaustive grid of small signed integers, run in all four rounding modes, exercises alignment, carry, cancellation and the zero-sign rule. Exact results there must not depend on the mode, and only x-x results change sign toward minus infinity. A difference that falls just below 1.0 splits the four modes into two result groups, and with the override inputs it shows which mode source was chosen. Directed cases cover overflow at the largest finite value, NaN and infinity priority, subnormal cancellation, and each masking and form combination, so that merge, zero, legacy and upper-lane handling can be told apart.

// File: rtl/fsub_pkg.sv
package fsub_pkg;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned VEC_W  = 128;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam logic [LANE_W-1:0] QNAN_DFLT = 32'hFFC0_0000;

  typedef enum logic [1:0] {
    RM_RNE = 2'b00,
    RM_RDN = 2'b01,
    RM_RUP = 2'b10,
    RM_RTZ = 2'b11
  } rmode_e;

  typedef struct packed {
    logic inv;
    logic den;
    logic ovf;
    logic unf;
    logic inx;
  } fsub_flags_t;
endpackage

// File: rtl/fsub_core.sv
module fsub_core
  import fsub_pkg::*;
(
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  rmode_e            rm_i,
  output logic [LANE_W-1:0] res_o,
  output fsub_flags_t       flags_o
);
  localparam int unsigned MW = FRAC_W + 1;
  localparam int unsigned XW = MW + 3;
  localparam int unsigned EW = EXP_W + 2;
  localparam logic [EW-1:0] E_OVF = EW'((1 << EXP_W) - 1);

  function automatic logic [EW-1:0] lzc(input logic [XW-1:0] v);
    logic [EW-1:0] n;
    logic          hit;
    n = EW'(XW);
    hit = 1'b0;
    for (int i = XW - 1; i >= 0; i--) begin
      if (v[i] && !hit) begin
        n = EW'(XW - 1 - i);
        hit = 1'b1;
      end
    end
    return n;
  endfunction

  logic              a_s, b_s;
  logic [EXP_W-1:0]  a_e, b_e;
  logic [FRAC_W-1:0] a_f, b_f;
  logic a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_dn, b_dn;

  assign {a_s, a_e, a_f} = a_i;
  assign {b_s, b_e, b_f} = b_i;
  assign a_nan  = (a_e == '1) && (a_f != '0);
  assign b_nan  = (b_e == '1) && (b_f != '0);
  assign a_snan = a_nan && !a_f[FRAC_W-1];
  assign b_snan = b_nan && !b_f[FRAC_W-1];
  assign a_inf  = (a_e == '1) && (a_f == '0);
  assign b_inf  = (b_e == '1) && (b_f == '0);
  assign a_dn   = (a_e == '0) && (a_f != '0);
  assign b_dn   = (b_e == '0) && (b_f != '0);

  // operand order by magnitude; subtrahend sign inverted
  logic              swap, l_s, s_s, eff_sub;
  logic [EXP_W-1:0]  l_er, s_er, l_e, s_e, d_e;
  logic [XW-1:0]     l_x, s_x, s_sh, s_lost, s_al;
  logic [XW:0]       sum;

  assign swap    = b_i[LANE_W-2:0] > a_i[LANE_W-2:0];
  assign l_s     = swap ? ~b_s : a_s;
  assign s_s     = swap ? a_s : ~b_s;
  assign l_er    = swap ? b_e : a_e;
  assign s_er    = swap ? a_e : b_e;
  assign l_e     = (l_er == '0) ? EXP_W'(1) : l_er;
  assign s_e     = (s_er == '0) ? EXP_W'(1) : s_er;
  assign d_e     = l_e - s_e;
  assign l_x     = {l_er != '0, swap ? b_f : a_f, 3'b000};
  assign s_x     = {s_er != '0, swap ? a_f : b_f, 3'b000};
  assign eff_sub = l_s ^ s_s;

  always_comb begin
    s_sh   = s_x >> d_e;
    s_lost = s_x & ~({XW{1'b1}} << d_e);
    if (d_e >= EXP_W'(XW)) s_al = {{(XW-1){1'b0}}, |s_x};
    else                   s_al = {s_sh[XW-1:1], s_sh[0] | (|s_lost)};
  end

  assign sum = eff_sub ? ({1'b0, l_x} - {1'b0, s_al}) : ({1'b0, l_x} + {1'b0, s_al});

  logic [EW-1:0] e_w, lz, lim, sh, e_n, e_r;
  logic [XW-1:0] norm;
  logic [MW-1:0] keep, man;
  logic [MW:0]   rnd;
  logic          g, st, lost_any, inc, big;

  assign e_w = EW'(l_e);
  assign lz  = lzc(sum[XW-1:0]);
  assign lim = e_w - EW'(1);
  assign sh  = (lz > lim) ? lim : lz;

  always_comb begin
    if (sum[XW]) begin
      norm = {sum[XW:2], sum[1] | sum[0]};
      e_n  = e_w + EW'(1);
    end else begin
      norm = sum[XW-1:0] << sh;
      e_n  = e_w - sh;
    end
  end

  assign keep     = norm[XW-1:3];
  assign g        = norm[2];
  assign st       = |norm[1:0];
  assign lost_any = g | st;

  always_comb begin
    unique case (rm_i)
      RM_RNE:  inc = g & (st | keep[0]);
      RM_RDN:  inc = lost_any & l_s;
      RM_RUP:  inc = lost_any & ~l_s;
      default: inc = 1'b0;
    endcase
  end

  assign rnd = {1'b0, keep} + {{MW{1'b0}}, inc};
  assign man = rnd[MW] ? rnd[MW:1] : rnd[MW-1:0];
  assign e_r = rnd[MW] ? e_n + EW'(1) : e_n;
  assign big = (rm_i == RM_RTZ) || (rm_i == RM_RDN && !l_s) || (rm_i == RM_RUP && l_s);

  always_comb begin
    flags_o     = '0;
    flags_o.den = a_dn | b_dn;
    if (a_snan || b_snan) begin
      res_o       = QNAN_DFLT;
      flags_o.inv = 1'b1;
    end else if (a_nan) begin
      res_o = a_i;
    end else if (b_nan) begin
      res_o = b_i;
    end else if (a_inf && b_inf && (a_s == b_s)) begin
      res_o       = QNAN_DFLT;
      flags_o.inv = 1'b1;
    end else if (a_inf) begin
      res_o = a_i;
    end else if (b_inf) begin
      res_o = {~b_s, b_i[LANE_W-2:0]};
    end else if (sum == '0) begin
      res_o = {eff_sub ? (rm_i == RM_RDN) : l_s, {(LANE_W-1){1'b0}}};
    end else if (e_r >= E_OVF) begin
      res_o       = big ? {l_s, E_OVF[EXP_W-1:0] - EXP_W'(1), {FRAC_W{1'b1}}}
                        : {l_s, E_OVF[EXP_W-1:0], {FRAC_W{1'b0}}};
      flags_o.ovf = 1'b1;
      flags_o.inx = 1'b1;
    end else begin
      res_o       = {l_s, man[MW-1] ? e_r[EXP_W-1:0] : {EXP_W{1'b0}}, man[FRAC_W-1:0]};
      flags_o.inx = lost_any;
      flags_o.unf = !man[MW-1];
    end
  end
endmodule

// File: rtl/fsub_lane_merge.sv
module fsub_lane_merge
  import fsub_pkg::*;
#(
  parameter int unsigned MAXVL = 512
) (
  input  logic              three_op_i,
  input  logic              mask_en_i,
  input  logic              mask_bit_i,
  input  logic              zero_mask_i,
  input  logic [VEC_W-1:0]  src1_i,
  input  logic [MAXVL-1:0]  dest_i,
  input  logic [LANE_W-1:0] diff_i,
  input  fsub_flags_t       flags_i,
  output logic [MAXVL-1:0]  dest_o,
  output fsub_flags_t       flags_o
);
  logic wr_en;

  // masking only exists in the masked three-operand form
  assign wr_en   = !(three_op_i && mask_en_i) || mask_bit_i;
  assign flags_o = wr_en ? flags_i : '0;

  assign dest_o[LANE_W-1:0] = wr_en       ? diff_i :
                              zero_mask_i ? '0     : dest_i[LANE_W-1:0];
  assign dest_o[VEC_W-1:LANE_W] = three_op_i ? src1_i[VEC_W-1:LANE_W]
                                             : dest_i[VEC_W-1:LANE_W];
  generate
    if (MAXVL > VEC_W) begin : g_wide
      assign dest_o[MAXVL-1:VEC_W] = three_op_i ? '0 : dest_i[MAXVL-1:VEC_W];
    end
  endgenerate
endmodule

// File: rtl/masked_fsub_unit.sv
module masked_fsub_unit
  import fsub_pkg::*;
#(
  parameter int unsigned MAXVL = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             three_op_i,
  input  logic             mask_en_i,
  input  logic             mask_bit_i,
  input  logic             zero_mask_i,
  input  logic             rc_ovr_i,
  input  logic [1:0]       rc_ovr_mode_i,
  input  logic [1:0]       rc_global_i,
  input  logic             src2_is_reg_i,
  input  logic [127:0]     src1_i,
  input  logic [127:0]     src2_i,
  input  logic [MAXVL-1:0] dest_i,
  output logic             valid_o,
  output logic [MAXVL-1:0] dest_o,
  output logic [4:0]       flags_o
);
  rmode_e             rm;
  logic [LANE_W-1:0]  op_a, diff;
  fsub_flags_t        core_fl, out_fl, flags_q;
  logic [MAXVL-1:0]   dest_d;

  assign rm   = (rc_ovr_i && src2_is_reg_i) ? rmode_e'(rc_ovr_mode_i) : rmode_e'(rc_global_i);
  assign op_a = three_op_i ? src1_i[LANE_W-1:0] : dest_i[LANE_W-1:0];

  fsub_core i_core (
    .a_i     (op_a),
    .b_i     (src2_i[LANE_W-1:0]),
    .rm_i    (rm),
    .res_o   (diff),
    .flags_o (core_fl)
  );

  fsub_lane_merge #(.MAXVL(MAXVL)) i_merge (
    .three_op_i  (three_op_i),
    .mask_en_i   (mask_en_i),
    .mask_bit_i  (mask_bit_i),
    .zero_mask_i (zero_mask_i),
    .src1_i      (src1_i),
    .dest_i      (dest_i),
    .diff_i      (diff),
    .flags_i     (core_fl),
    .dest_o      (dest_d),
    .flags_o     (out_fl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dest_o  <= '0;
      flags_q <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dest_o  <= dest_d;
        flags_q <= out_fl;
      end
    end
  end

  assign flags_o = flags_q;

  a_r11_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(dest_o) && $stable(flags_o));
  a_r10_legacy_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !three_op_i |=> dest_o[MAXVL-1:LANE_W] == $past(dest_i[MAXVL-1:LANE_W]));
  a_r8_merge_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && three_op_i && mask_en_i && !mask_bit_i && !zero_mask_i
    |=> dest_o[LANE_W-1:0] == $past(dest_i[LANE_W-1:0]) && flags_o == '0);
  a_r4_invalid_dflt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && flags_o[4] |-> dest_o[LANE_W-1:0] == QNAN_DFLT);
  a_r7_unf_tiny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && flags_o[1] |-> dest_o[30:23] == '0);
  generate
    if (MAXVL > VEC_W) begin : g_chk_wide
      a_r9_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && three_op_i |=> dest_o[MAXVL-1:VEC_W] == '0);
    end
  endgenerate
endmodule

// File: tb/test_masked_fsub_unit.sv
module test_masked_fsub_unit;
  localparam int MAXVL = 512;
  localparam logic [4:0] F_INV = 5'b10000, F_DEN = 5'b01000, F_OVF = 5'b00100,
                         F_UNF = 5'b00010, F_INX = 5'b00001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, three_op = 1'b1, mask_en = 1'b0, mask_bit = 1'b0, zero_m = 1'b0;
  logic rc_ovr = 1'b0, s2_reg = 1'b1;
  logic [1:0] rc_ovr_mode = 2'b00, rc_glob = 2'b00;
  logic [127:0] src1 = '0, src2 = '0;
  logic [MAXVL-1:0] dest_in = '0;
  logic valid_o;
  logic [MAXVL-1:0] dest_out;
  logic [4:0] flags;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  masked_fsub_unit #(.MAXVL(MAXVL)) i_masked_fsub_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .three_op_i(three_op),
    .mask_en_i(mask_en), .mask_bit_i(mask_bit), .zero_mask_i(zero_m),
    .rc_ovr_i(rc_ovr), .rc_ovr_mode_i(rc_ovr_mode), .rc_global_i(rc_glob),
    .src2_is_reg_i(s2_reg), .src1_i(src1), .src2_i(src2), .dest_i(dest_in),
    .valid_o(valid_o), .dest_o(dest_out), .flags_o(flags)
  );

  function automatic logic [31:0] f_of_int(input int v);
    int m, p;
    logic [31:0] t;
    if (v == 0) return 32'h0;
    m = (v < 0) ? -v : v;
    p = 0;
    for (int i = 0; i < 31; i++) if (m >= (1 << i)) p = i;
    t = 32'(m) << (23 - p);
    return {v < 0, 8'(127 + p), t[22:0]};
  endfunction

  task automatic check(input string tag, input logic [MAXVL-1:0] act, exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // keep_lo: expected low lane is the old destination lane
  task automatic run(input string tag, input logic [31:0] a, b,
                     input logic thr, men, mbit, zm, ovr, input logic [1:0] orc, grc,
                     input logic s2r, keep_lo, input logic [31:0] exp_lo,
                     input logic [4:0] exp_fl);
    logic [127:0] s1;
    logic [MAXVL-1:0] dold, exp_d;
    s1   = {32'hA5A5_0000 ^ 32'(n_chk), 32'h1234_5678, 32'hDEAD_BEEF, 32'h0};
    dold = {(MAXVL/32){32'h5A5A_C3C3 ^ 32'(n_chk)}};
    if (thr) s1[31:0] = a;
    else begin dold[31:0] = a; s1[31:0] = ~a; end
    exp_d = dold;
    exp_d[31:0] = keep_lo ? dold[31:0] : exp_lo;
    if (thr) begin exp_d[MAXVL-1:128] = '0; exp_d[127:32] = s1[127:32]; end
    @(negedge clk);
    src1 = s1; src2 = {96'h0, b}; dest_in = dold; three_op = thr;
    mask_en = men; mask_bit = mbit; zero_m = zm; rc_ovr = ovr;
    rc_ovr_mode = orc; rc_glob = grc; s2_reg = s2r; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check({tag, " R11 valid"}, MAXVL'(valid_o), MAXVL'(1'b1));
    check({tag, " dest"}, dest_out, exp_d);
    check({tag, " flags"}, MAXVL'(flags), MAXVL'(exp_fl));
  endtask

  task automatic plain(input string tag, input logic [31:0] a, b, input logic [1:0] rm,
                       input logic [31:0] e, input logic [4:0] fl);
    run(tag, a, b, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, rm, 1'b1, 1'b0, e, fl);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL R11 watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [MAXVL-1:0] held;
    repeat (3) @(negedge clk);
    check("R11 reset valid", MAXVL'(valid_o), '0);
    check("R11 reset dest", dest_out, '0);
    check("R11 reset flags", MAXVL'(flags), '0);
    rst_n = 1'b1;

    // R1 R6 integer grid in every mode; R8 mask bit set still writes
    for (int rm = 0; rm < 4; rm++)
      for (int a = -16; a <= 16; a++)
        for (int b = -16; b <= 16; b++)
          run("R1 grid", f_of_int(a), f_of_int(b), 1'b1, (a & 1) != 0, 1'b1, 1'b0, 1'b0,
              2'b00, 2'(rm), 1'b1, 1'b0,
              (a == b) ? ((rm == 1) ? 32'h8000_0000 : 32'h0) : f_of_int(a - b), 5'b0);

    // R2 rounding just below one
    plain("R2 rne", 32'h3F80_0000, 32'h3080_0000, 2'b00, 32'h3F80_0000, F_INX);
    plain("R2 rdn", 32'h3F80_0000, 32'h3080_0000, 2'b01, 32'h3F7F_FFFF, F_INX);
    plain("R2 rup", 32'h3F80_0000, 32'h3080_0000, 2'b10, 32'h3F80_0000, F_INX);
    plain("R2 rtz", 32'h3F80_0000, 32'h3080_0000, 2'b11, 32'h3F7F_FFFF, F_INX);
    run("R2 ovr used", 32'h3F80_0000, 32'h3080_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1,
        2'b11, 2'b00, 1'b1, 1'b0, 32'h3F7F_FFFF, F_INX);
    run("R2 ovr mem src", 32'h3F80_0000, 32'h3080_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1,
        2'b11, 2'b00, 1'b0, 1'b0, 32'h3F80_0000, F_INX);
    run("R2 ovr off", 32'h3F80_0000, 32'h3080_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
        2'b11, 2'b00, 1'b1, 1'b0, 32'h3F80_0000, F_INX);

    // R3 overflow
    plain("R3 rne", 32'h7F7F_FFFF, 32'hFF7F_FFFF, 2'b00, 32'h7F80_0000, F_OVF | F_INX);
    plain("R3 rdn", 32'h7F7F_FFFF, 32'hFF7F_FFFF, 2'b01, 32'h7F7F_FFFF, F_OVF | F_INX);
    plain("R3 rup", 32'h7F7F_FFFF, 32'hFF7F_FFFF, 2'b10, 32'h7F80_0000, F_OVF | F_INX);
    plain("R3 rtz", 32'h7F7F_FFFF, 32'hFF7F_FFFF, 2'b11, 32'h7F7F_FFFF, F_OVF | F_INX);
    plain("R3 neg rdn", 32'hFF7F_FFFF, 32'h7F7F_FFFF, 2'b01, 32'hFF80_0000, F_OVF | F_INX);
    plain("R3 neg rup", 32'hFF7F_FFFF, 32'h7F7F_FFFF, 2'b10, 32'hFF7F_FFFF, F_OVF | F_INX);

    // R4 R5 specials
    plain("R4 inf-inf", 32'h7F80_0000, 32'h7F80_0000, 2'b00, 32'hFFC0_0000, F_INV);
    plain("R4 snan", 32'h7F80_0001, 32'h3F80_0000, 2'b00, 32'hFFC0_0000, F_INV);
    plain("R4 snan b", 32'h7FC0_0001, 32'hFF80_0002, 2'b00, 32'hFFC0_0000, F_INV);
    plain("R5 qnan prio", 32'h7FC0_0001, 32'h7FC0_0002, 2'b00, 32'h7FC0_0001, 5'b0);
    plain("R5 qnan b", 32'h3F80_0000, 32'hFFC0_0005, 2'b00, 32'hFFC0_0005, 5'b0);
    plain("R5 inf-ninf", 32'h7F80_0000, 32'hFF80_0000, 2'b00, 32'h7F80_0000, 5'b0);
    plain("R5 x-inf", 32'h3F80_0000, 32'h7F80_0000, 2'b00, 32'hFF80_0000, 5'b0);

    // R6 zeros
    plain("R6 p0-n0", 32'h0000_0000, 32'h8000_0000, 2'b01, 32'h0000_0000, 5'b0);
    plain("R6 n0-p0", 32'h8000_0000, 32'h0000_0000, 2'b00, 32'h8000_0000, 5'b0);
    plain("R6 x-x rdn", 32'h4049_0FDB, 32'h4049_0FDB, 2'b01, 32'h8000_0000, 5'b0);
    plain("R6 x-x rup", 32'h4049_0FDB, 32'h4049_0FDB, 2'b10, 32'h0000_0000, 5'b0);

    // R7 subnormals
    plain("R7 sub-sub", 32'h0000_0003, 32'h0000_0001, 2'b00, 32'h0000_0002, F_DEN | F_UNF);
    plain("R7 norm-sub", 32'h0080_0000, 32'h0000_0001, 2'b00, 32'h007F_FFFF, F_DEN | F_UNF);
    plain("R7 to normal", 32'h0080_0001, 32'h0000_0001, 2'b00, 32'h0080_0000, F_DEN);
    plain("R7 tiny diff", 32'h0080_0000, 32'h0080_0001, 2'b11, 32'h8000_0001, F_UNF);

    // R8 masking in the three-operand form
    run("R8 merge", 32'h7F80_0000, 32'h7F80_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00,
        2'b00, 1'b1, 1'b1, 32'h0, 5'b0);
    run("R8 zero", 32'h7F80_0000, 32'h7F80_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00,
        2'b00, 1'b1, 1'b0, 32'h0, 5'b0);
    run("R8 bit set", 32'h4000_0000, 32'h3F80_0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00,
        2'b00, 1'b1, 1'b0, 32'h3F80_0000, 5'b0);
    // R9 upper lanes covered by every three-operand run; R10 legacy form
    run("R10 legacy zero mask", 32'h4040_0000, 32'h3F80_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
        2'b00, 2'b00, 1'b1, 1'b0, 32'h4000_0000, 5'b0);
    run("R10 legacy merge", 32'hC000_0000, 32'h4000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
        2'b00, 2'b00, 1'b1, 1'b0, 32'hC080_0000, 5'b0);
    run("R10 unmasked", 32'h4000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0,
        2'b00, 2'b00, 1'b1, 1'b0, 32'h0, 5'b0);

    // R11 hold without strobe
    held = dest_out;
    @(negedge clk);
    src1 = '1; src2 = 128'h3F80_0000; dest_in = '1; three_op = 1'b1;
    @(negedge clk);
    check("R11 idle valid", MAXVL'(valid_o), '0);
    check("R11 idle hold", dest_out, held);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule